// File: doc/BRIEF.md
# Statically Scheduled Single-Bit Logic Emulation Processor

This block is one processing element of a logic-emulation array. A compiler turns the design to be emulated into a fixed schedule of single-bit gate evaluations. That schedule is loaded into the element's instruction memory while it is stopped. Once started, the element walks the schedule one step per clock, from slot 0 to the last slot, with no branches. Each complete walk stands for one clock of the emulated design. On every step it evaluates one configurable four-input gate and writes the result into a local data store at the slot owned by that step. The same result leaves the element on `out_bit`.

Operands come from four places. Each can be read from the data store, which holds this element's earlier results. Each can also be read from the input store, which keeps one interconnect bit per step, taken from the network source that the instruction names. One operand per step may instead be replaced by a bit from one of the six nearest neighbours, three on each side. The neighbour path saves the step that a network bit spends landing in the input store.

Each instruction word has a left half and a right half. The left half holds the operand routing and the control fields. The right half is a 16-entry truth table in logic mode. In memory mode, the right half is an 8-bit data array that the step reads and may rewrite.

Top module: `emu_proc`

## Requirements
- R1: While `run` is high, one step executes per clock and the steps are taken in order 0, 1, ..., 127, then 0 again. While `run` is low, the step counter is forced to 0, so every start begins at step 0. While stopped, `out_bit` holds its value.
- R2: `pass_done` is high for exactly the one cycle that follows the clock edge that executed step 127, and it is low at all other times.
- R3: The result of step k is written into data-store slot k. A read of slot k during step k returns the previous contents. Values persist across passes until they are rewritten. Operand i occupies left bits [8i+7:8i]. Bit 8i+7 chooses the store (1 = input store, 0 = data store), and bits [8i+6:8i] give the slot.
- R4: At step k, the network bit `net_in[left[40:38]]` is written into input-store slot k, unless left bit 41 is 1 (ignore). In that case the slot keeps its old value. A bit stored at step k can be read from step k+1 on.
- R5: When left bit 37 is 1, the operand numbered left[36:35] is replaced by `nbr_in[left[34:32]]` within the same step. `nbr_in[2:0]` are the neighbours at distance 1..3 on one side, and `nbr_in[5:3]` are those on the other side. Select codes 6 and 7 give 0.
- R6: In logic mode (left bit 42 = 0), the result is `right[{op3,op2,op1,op0}]`. It appears on `out_bit` after the edge that executes the step. `prog_data[59:44]` is the right half and `prog_data[43:0]` is the left half.
- R7: In memory mode (left bit 42 = 1), the result is the current `right[{op2,op1,op0}]`. When left bit 43 is 1, that bit of this step's right half is then replaced by op3, and the new value is seen from the next pass on.
- R8: An instruction-memory write (`prog_we`) is accepted only while `run` is low. Writes attempted while running have no effect.
- R9: After reset, `out_bit` and `pass_done` are 0 and every slot of both stores reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | High to execute steps, low to stop and rewind |
| prog_we | input | 1 | Instruction write strobe (only taken when stopped) |
| prog_addr | input | 7 | Instruction slot to write |
| prog_data | input | 60 | Instruction word, right half in [59:44], left half in [43:0] |
| net_in | input | 8 | Bits offered by the interconnect, one per source |
| nbr_in | input | 6 | Direct bits from the three neighbours on each side |
| out_bit | output | 1 | Registered result of the most recent step |
| pass_done | output | 1 | One-cycle marker accompanying the result of step 127 |

## Verification
On every cycle, the assertions check the sequencing: the counter advances by one while running, wraps after the last step, and sits at 0 while stopped. They also check that `pass_done` follows the final step alone and that the output is frozen while stopped. The stored-data semantics can only be shown by the bench's scenarios, which compare `out_bit` step by step against an arithmetic model. These semantics are read-old behaviour, persistence across passes, the one-step delay of network bits against the zero-delay neighbour path, the ignore flag, memory-mode write-back, and the rejection of program writes while running.

// File: rtl/emu_pkg.sv
package emu_pkg;
  localparam int NOPS      = 4;
  localparam int STEPS     = 128;
  localparam int AW        = $clog2(STEPS);
  localparam int NBR_SIDE  = 3;
  localparam int NBR       = 2 * NBR_SIDE;
  localparam int NBR_SEL_W = $clog2(NBR);
  localparam int NET_SRCS  = 8;
  localparam int NET_W     = $clog2(NET_SRCS);
  localparam int SLOT_W    = $clog2(NOPS);
  localparam int TT_W      = 1 << NOPS;
  localparam int MEM_AW    = NOPS - 1;

  typedef struct packed {
    logic          from_in;
    logic [AW-1:0] addr;
  } opnd_t;

  typedef struct packed {
    logic                 mem_wr;
    logic                 mem_mode;
    logic                 net_ign;
    logic [NET_W-1:0]     net_src;
    logic                 nb_en;
    logic [SLOT_W-1:0]    nb_slot;
    logic [NBR_SEL_W-1:0] nb_src;
    opnd_t [NOPS-1:0]     ops;
  } left_t;

  localparam int LEFT_W  = $bits(left_t);
  localparam int RIGHT_W = TT_W;
  localparam int WORD_W  = LEFT_W + RIGHT_W;
endpackage

// File: rtl/emu_seq.sv
module emu_seq #(
  parameter int STEPS = 128,
  localparam int AW = $clog2(STEPS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  output logic [AW-1:0] step,
  output logic          pass_done
);
  localparam logic [AW-1:0] LAST = AW'(STEPS - 1);

  logic at_last;
  assign at_last = (step == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      step      <= '0;
      pass_done <= 1'b0;
    end else begin
      pass_done <= run && at_last;
      if (!run || at_last) step <= '0;
      else                 step <= step + AW'(1);
    end
  end
endmodule

// File: rtl/emu_imem.sv
module emu_imem #(
  parameter int DEPTH = 128,
  parameter int LW    = 44,
  parameter int RW    = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            run,
  input  logic            host_we,
  input  logic [AW-1:0]   host_addr,
  input  logic [LW+RW-1:0] host_data,
  input  logic [AW-1:0]   rd_addr,
  input  logic            wb_we,
  input  logic [RW-1:0]   wb_right,
  output logic [LW-1:0]   rd_left,
  output logic [RW-1:0]   rd_right
);
  logic [LW-1:0] left_mem  [DEPTH];
  logic [RW-1:0] right_mem [DEPTH];

  // control half: written only from the host port
  always_ff @(posedge clk) begin
    if (!run && host_we) left_mem[host_addr] <= host_data[LW-1:0];
  end

  // data half: host port when stopped, memory-mode write-back when running
  always_ff @(posedge clk) begin
    if (!run && host_we)   right_mem[host_addr] <= host_data[LW+RW-1:LW];
    else if (run && wb_we) right_mem[rd_addr]   <= wb_right;
  end

  assign rd_left  = left_mem[rd_addr];
  assign rd_right = right_mem[rd_addr];
endmodule

// File: rtl/emu_bitstore.sv
module emu_bitstore #(
  parameter int DEPTH = 128,
  parameter int NRD   = 4,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [AW-1:0]           waddr,
  input  logic                    wbit,
  input  logic [NRD-1:0][AW-1:0]  raddr,
  output logic [NRD-1:0]          rbit
);
  logic [DEPTH-1:0] cells;

  always_ff @(posedge clk) begin
    if (rst)     cells        <= '0;
    else if (we) cells[waddr] <= wbit;
  end

  // reads see the contents before this step's write
  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rbit[g] = cells[raddr[g]];
  end
endmodule

// File: rtl/emu_gate.sv
module emu_gate
  import emu_pkg::*;
(
  input  left_t            instr,
  input  logic [TT_W-1:0]  tt,
  input  logic [NOPS-1:0]  dbits,
  input  logic [NOPS-1:0]  ibits,
  input  logic [NBR-1:0]   nbr,
  output logic             result,
  output logic             mem_we,
  output logic [TT_W-1:0]  tt_next
);
  localparam int NB_PAD = 1 << NBR_SEL_W;

  logic [NB_PAD-1:0] nb_pad;
  logic              nb_bit;
  logic [NOPS-1:0]   v;
  logic [MEM_AW-1:0] mem_addr;

  assign nb_pad = {{(NB_PAD - NBR){1'b0}}, nbr};
  assign nb_bit = nb_pad[instr.nb_src];

  for (genvar i = 0; i < NOPS; i++) begin : g_op
    assign v[i] = (instr.nb_en && instr.nb_slot == SLOT_W'(i)) ? nb_bit :
                  (instr.ops[i].from_in ? ibits[i] : dbits[i]);
  end

  assign mem_addr = v[MEM_AW-1:0];
  assign result   = instr.mem_mode ? tt[mem_addr] : tt[v];
  assign mem_we   = instr.mem_mode && instr.mem_wr;

  always_comb begin
    tt_next           = tt;
    tt_next[mem_addr] = v[NOPS-1];
  end
endmodule

// File: rtl/emu_proc.sv
module emu_proc
  import emu_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                run,
  input  logic                prog_we,
  input  logic [AW-1:0]       prog_addr,
  input  logic [WORD_W-1:0]   prog_data,
  input  logic [NET_SRCS-1:0] net_in,
  input  logic [NBR-1:0]      nbr_in,
  output logic                out_bit,
  output logic                pass_done
);
  logic [AW-1:0]            step_idx;
  logic [LEFT_W-1:0]        cur_left;
  logic [RIGHT_W-1:0]       cur_right;
  left_t                    instr;
  logic [NOPS-1:0][AW-1:0]  rd_addr;
  logic [NOPS-1:0]          dbits;
  logic [NOPS-1:0]          ibits;
  logic                     result;
  logic                     wb_we;
  logic [RIGHT_W-1:0]       wb_right;

  emu_seq #(.STEPS(STEPS)) u_seq (
    .clk(clk), .rst(rst), .run(run), .step(step_idx), .pass_done(pass_done)
  );

  emu_imem #(.DEPTH(STEPS), .LW(LEFT_W), .RW(RIGHT_W)) u_imem (
    .clk(clk), .run(run), .host_we(prog_we), .host_addr(prog_addr),
    .host_data(prog_data), .rd_addr(step_idx), .wb_we(wb_we),
    .wb_right(wb_right), .rd_left(cur_left), .rd_right(cur_right)
  );

  assign instr = left_t'(cur_left);

  for (genvar i = 0; i < NOPS; i++) begin : g_addr
    assign rd_addr[i] = instr.ops[i].addr;
  end

  emu_bitstore #(.DEPTH(STEPS), .NRD(NOPS)) u_dstore (
    .clk(clk), .rst(rst), .we(run), .waddr(step_idx), .wbit(result),
    .raddr(rd_addr), .rbit(dbits)
  );

  emu_bitstore #(.DEPTH(STEPS), .NRD(NOPS)) u_istore (
    .clk(clk), .rst(rst), .we(run && !instr.net_ign), .waddr(step_idx),
    .wbit(net_in[instr.net_src]), .raddr(rd_addr), .rbit(ibits)
  );

  emu_gate u_gate (
    .instr(instr), .tt(cur_right), .dbits(dbits), .ibits(ibits),
    .nbr(nbr_in), .result(result), .mem_we(wb_we), .tt_next(wb_right)
  );

  always_ff @(posedge clk) begin
    if (rst)      out_bit <= 1'b0;
    else if (run) out_bit <= result;
  end
endmodule

// File: rtl/emu_proc_chk.sv
module emu_proc_chk
  import emu_pkg::*;
(
  input logic          clk,
  input logic          rst,
  input logic          run,
  input logic [AW-1:0] step_idx,
  input logic          out_bit,
  input logic          pass_done
);
  localparam logic [AW-1:0] LAST = AW'(STEPS - 1);

  // R1
  step_adv_chk: assert property (@(posedge clk) disable iff (rst)
    (run && step_idx != LAST) |=> step_idx == $past(step_idx) + AW'(1));

  // R1
  step_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (run && step_idx == LAST) |=> step_idx == '0);

  // R1
  stop_rewind_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> step_idx == '0);

  // R1
  stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(out_bit));

  // R2
  done_mark_chk: assert property (@(posedge clk) disable iff (rst)
    (run && step_idx == LAST) |=> pass_done);

  // R2
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    pass_done |=> !pass_done);

  // R2
  done_stopped_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> !pass_done);
endmodule

bind emu_proc emu_proc_chk u_chk (
  .clk(clk), .rst(rst), .run(run), .step_idx(step_idx),
  .out_bit(out_bit), .pass_done(pass_done)
);

// File: tb/emu_proc_tb.sv
`timescale 1ns/1ps
module emu_proc_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run = 1'b0;
  logic        prog_we = 1'b0;
  logic [6:0]  prog_addr = '0;
  logic [59:0] prog_data = '0;
  logic [7:0]  net_in = '0;
  logic [5:0]  nbr_in = '0;
  logic        out_bit;
  logic        pass_done;

  int checks = 0;
  int fails  = 0;

  logic [43:0] m_l [128];
  logic [15:0] m_r [128];
  logic        m_d [128];
  logic        m_i [128];
  int          mk = 0;

  always #2 clk = ~clk;

  emu_proc dut_i (
    .clk(clk), .rst(rst), .run(run), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_data(prog_data), .net_in(net_in), .nbr_in(nbr_in),
    .out_bit(out_bit), .pass_done(pass_done)
  );

  task automatic chk(string req, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", req, got, exp);
    end
  endtask

  task automatic load_word(int a, logic [43:0] l, logic [15:0] r);
    @(negedge clk);
    prog_we   = 1'b1;
    prog_addr = a[6:0];
    prog_data = {r, l};
    @(negedge clk);
    prog_we   = 1'b0;
    m_l[a] = l;
    m_r[a] = r;
  endtask

  // build and load a program; percentages steer operand sources and modes
  task automatic gen_prog(int p_in, int p_nb, int p_mem, bit selfref);
    for (int k = 0; k < 128; k++) begin
      logic [63:0] rnd;
      logic [43:0] l;
      logic [15:0] r;
      rnd = {$urandom(), $urandom()};
      l = rnd[43:0];
      r = rnd[59:44];
      for (int i = 0; i < 4; i++) l[8*i+7] = (($urandom() % 100) < p_in);
      l[37] = (($urandom() % 100) < p_nb);
      l[42] = (($urandom() % 100) < p_mem);
      if (selfref) begin
        l[7:0] = {1'b0, 7'(k)};
        l[37]  = 1'b0;
        l[42]  = 1'b0;
        r      = 16'h5555;
      end
      load_word(k, l, r);
    end
  endtask

  task automatic start_run();
    @(negedge clk);
    run = 1'b1;
    mk  = 0;
  endtask

  task automatic stop_run();
    run     = 1'b0;
    prog_we = 1'b0;
    @(posedge clk);
    @(negedge clk);
    mk = 0;
  endtask

  // one step per iteration; called at a falling edge, returns at a falling edge
  task automatic run_steps(int n, string lab, bit jam);
    for (int s = 0; s < n; s++) begin
      logic [43:0] l;
      logic [15:0] r;
      logic [3:0]  v;
      logic        e;
      logic        done_exp;
      net_in = 8'($urandom());
      nbr_in = 6'($urandom());
      if (jam) begin
        prog_we   = 1'b1;
        prog_addr = 7'($urandom());
        prog_data = {$urandom(), $urandom()};
      end
      l = m_l[mk];
      r = m_r[mk];
      for (int i = 0; i < 4; i++) begin
        int a;
        a = int'(l[8*i +: 7]);
        v[i] = l[8*i+7] ? m_i[a] : m_d[a];
        if (l[37] && int'(l[36:35]) == i)
          v[i] = (l[34:32] < 3'd6) ? nbr_in[l[34:32]] : 1'b0;
      end
      if (l[42]) begin
        e = r[v[2:0]];
        if (l[43]) m_r[mk][v[2:0]] = v[3];
      end else begin
        e = r[v];
      end
      m_d[mk] = e;
      if (!l[41]) m_i[mk] = net_in[l[40:38]];
      done_exp = (mk == 127);
      @(posedge clk);
      @(negedge clk);
      chk(lab, out_bit, e);
      chk("R2", pass_done, done_exp);
      mk = (mk + 1) % 128;
    end
    prog_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic held;
    for (int k = 0; k < 128; k++) begin
      m_d[k] = 1'b0;
      m_i[k] = 1'b0;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state at the ports
    chk("R9", out_bit, 1'b0);
    chk("R9", pass_done, 1'b0);

    // R9 first pass reads cleared stores; R6 logic mode over more passes
    gen_prog(0, 0, 0, 1'b0);
    start_run();
    run_steps(128, "R9", 1'b0);
    run_steps(256, "R6", 1'b0);
    stop_run();

    // R1 output frozen while stopped
    held = out_bit;
    repeat (5) @(negedge clk);
    chk("R1", out_bit, held);
    chk("R2", pass_done, 1'b0);

    // R3 each step inverts its own slot: read-old and persistence
    gen_prog(0, 0, 0, 1'b1);
    start_run();
    run_steps(384, "R3", 1'b0);
    stop_run();

    // R4 operands mostly from the input store, ignore flag random
    gen_prog(70, 0, 0, 1'b0);
    start_run();
    run_steps(256, "R4", 1'b0);
    stop_run();

    // R5 neighbour bypass
    gen_prog(20, 60, 0, 1'b0);
    start_run();
    run_steps(256, "R5", 1'b0);
    stop_run();

    // R7 memory mode with write-back
    gen_prog(30, 20, 60, 1'b0);
    start_run();
    run_steps(384, "R7", 1'b0);
    stop_run();

    // R8 host writes while running are dropped
    gen_prog(40, 30, 30, 1'b0);
    start_run();
    run_steps(200, "R8", 1'b1);
    run_steps(200, "R8", 1'b0);
    // R1 stop mid-pass, restart from step 0
    stop_run();
    start_run();
    run_steps(256, "R1", 1'b0);
    stop_run();

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule